// File: doc/BRIEF.md
# Indexed predicate select unit

This unit executes one scalable-vector instruction that conditionally copies a predicate register. A guard predicate is tested at a single element position. That position is an index register plus a small immediate, wrapped to the number of elements in the vector. If the guard element is active, the destination predicate receives the whole of a source predicate. Otherwise the destination is written with all zeros. The element size and the immediate are both packed into one priority-coded five-bit field of the instruction word.

The unit sits beside a predicate register file. Each cycle it sees the whole file as one flat vector, along with the four index registers that the instruction can name. It accepts a new instruction on every cycle. One clock after an instruction is accepted, it either requests a write, flags the encoding as undefined, or reports that the word is some other instruction. The vector length is a parameter. The latency is one cycle for every operand value.

Top module: `idx_psel_unit`

## Requirements
- R1: An issued word is recognised only if bits 31:24 are 8'h25, bit 21 is 1, bits 15:14 are 2'b01, bit 9 is 0 and bit 4 is 0. For any other issued word, `op_foreign` is high for one cycle, one clock later, and no write or undefined flag is raised.
- R2: A recognised word whose size code {bit 22, bits 20:18} is 4'b0000 raises `op_undef` for one cycle, one clock later, and requests no write.
- R3: The size code picks the element size from its lowest set bit. Bit 0 set means 8 bits, lowest set bit 1 means 16, bit 2 means 32, and code 4'b1000 means 64. The immediate is the top 4, 3, 2 or 1 bits of {bit 23, bit 22, bits 20:18}, in that order.
- R4: The tested element is (index + immediate) modulo (VL / element size). The sum is formed without loss, so an index of 32'hFFFF_FFFF wraps correctly.
- R5: An element counts as active when the guard bit at position element × (element size / 8) is set. Other guard bits inside that element have no effect.
- R6: The guard register is named by bits 13:10, the source by bits 8:5 and the destination by bits 3:0. On an active element, `wr_data` equals the source register's whole contents. Otherwise `wr_data` is zero. In both cases `wr_addr` is the destination field.
- R7: The index is the 32-bit word k of `idx_regs`, where k is bits 17:16. Word k holds index register 12+k.
- R8: `in_ready` is always high. A write, undefined flag or foreign flag appears exactly one clock after a cycle with `in_valid` high, lasts one cycle, and never appears otherwise.
- R9: While reset is low, `wr_en`, `op_undef` and `op_foreign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction issue strobe |
| in_ready | output | 1 | Unit can accept an instruction (always high) |
| insn | input | 32 | Instruction word |
| pred_file | input | 16*VL/8 | All predicate registers; register r occupies bits r*VL/8 upward |
| idx_regs | input | 128 | Index registers 12..15, word k is register 12+k |
| wr_en | output | 1 | Predicate write request |
| wr_addr | output | 4 | Destination predicate number |
| wr_data | output | VL/8 | Value to write |
| op_undef | output | 1 | Undefined size encoding seen |
| op_foreign | output | 1 | Issued word is not this instruction |

## Verification
The hardest case to reach from the ports is a guard that passes or fails only because of the wrap and the element stride. The set bit must sit at exactly element × stride after a carry out of the 32-bit sum, or a guard bit inside the element but off its first byte must be ignored. The stimulus table chooses index and immediate pairs that overflow 32 bits or wrap past the element count. It pairs each of these with guard patterns that set the neighbouring bits but not the tested one. The index registers that were not selected are loaded with values that would move the tested position, so a wrong register choice changes the result.

// File: rtl/idx_psel_unit.sv
module idx_psel_unit #(
  parameter int VL = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          insn,
  input  logic [16*VL/8-1:0]   pred_file,
  input  logic [127:0]         idx_regs,
  output logic                 wr_en,
  output logic [3:0]           wr_addr,
  output logic [VL/8-1:0]      wr_data,
  output logic                 op_undef,
  output logic                 op_foreign
);
  localparam int PL  = VL / 8;
  localparam int LPL = $clog2(PL);

  logic [3:0]     tsz;
  logic [4:0]     imm5;
  logic [1:0]     sh;
  logic [3:0]     imm;
  logic           match, bad_size;
  logic [31:0]    idx;
  logic [32:0]    sum;
  logic [LPL-1:0] mask, elem, bitpos;
  logic [PL-1:0]  pn_val, pm_val;
  logic           hit;

  assign in_ready = 1'b1;
  assign tsz      = {insn[22], insn[20:18]};
  assign imm5     = {insn[23], tsz};
  assign match    = insn[31:24] == 8'h25 && insn[21] && insn[15:14] == 2'b01
                    && !insn[9] && !insn[4];
  assign bad_size = tsz == 4'b0000;

  always_comb begin
    if (tsz[0]) begin
      sh = 2'd0; imm = imm5[4:1];
    end else if (tsz[1]) begin
      sh = 2'd1; imm = {1'b0, imm5[4:2]};
    end else if (tsz[2]) begin
      sh = 2'd2; imm = {2'b0, imm5[4:3]};
    end else begin
      sh = 2'd3; imm = {3'b0, imm5[4]};
    end
  end

  assign idx    = idx_regs[insn[17:16]*32 +: 32];
  assign sum    = {1'b0, idx} + {29'b0, imm};
  assign mask   = LPL'(PL - 1) >> sh;
  assign elem   = sum[LPL-1:0] & mask;
  assign bitpos = elem << sh;
  assign pn_val = pred_file[insn[8:5]*PL +: PL];
  assign pm_val = pred_file[insn[13:10]*PL +: PL];
  assign hit    = pm_val[bitpos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      op_undef   <= 1'b0;
      op_foreign <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en      <= in_valid && match && !bad_size;
      op_undef   <= in_valid && match && bad_size;
      op_foreign <= in_valid && !match;
      if (in_valid) begin
        wr_addr <= insn[3:0];
        wr_data <= hit ? pn_val : '0;
      end
    end
  end
endmodule

// File: rtl/idx_psel_chk.sv
module idx_psel_chk #(
  parameter int VL = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [31:0]        insn,
  input logic [16*VL/8-1:0] pred_file,
  input logic [127:0]       idx_regs,
  input logic               wr_en,
  input logic [3:0]         wr_addr,
  input logic [VL/8-1:0]    wr_data,
  input logic               op_undef,
  input logic               op_foreign
);
  localparam int PL = VL / 8;
  logic [PL-1:0] src_now, grd_now;
  assign src_now = pred_file[insn[8:5]*PL +: PL];
  assign grd_now = pred_file[insn[13:10]*PL +: PL];

  initial begin
    assert (VL >= 128 && VL <= 2048 && (VL & (VL - 1)) == 0)
      else $error("VL must be a power of two in 128..2048");
  end

  p_issue_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || op_undef || op_foreign) |-> $past(in_valid));
  p_outcome_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, op_undef, op_foreign}));
  p_no_write_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_undef |-> !wr_en);
  p_dest_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr == $past(insn[3:0]));
  p_copy_or_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == '0 || wr_data == $past(src_now)));
  p_empty_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(grd_now) == '0) |-> wr_data == '0);
  p_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[9]) |=> (op_foreign && !wr_en));
endmodule

bind idx_psel_unit idx_psel_chk #(.VL(VL)) u_chk (.*);

// File: tb/test_idx_psel_unit.sv
module test_idx_psel_unit;
  localparam int VL = 256;
  localparam int PL = VL / 8;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic in_ready;
  logic [31:0] insn = '0;
  logic [16*PL-1:0] pred_file = '0;
  logic [127:0] idx_regs = '0;
  logic wr_en, op_undef, op_foreign;
  logic [3:0] wr_addr;
  logic [PL-1:0] wr_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  idx_psel_unit #(.VL(VL)) i_idx_psel_unit (.*);

  localparam logic [31:0] SRC = 32'hC3A5_5A3C;

  // {imm5, rv, index, guard, expected hit}
  localparam logic [71:0] VEC [11] = '{
    {5'b00011, 2'd0, 32'h0000_0004, 32'h0000_0020, 1'b1},
    {5'b00011, 2'd1, 32'h0000_0004, 32'h0000_0010, 1'b0},
    {5'b11111, 2'd2, 32'hFFFF_FFFF, 32'h0000_4000, 1'b1},
    {5'b10110, 2'd3, 32'h0000_0003, 32'h0001_0000, 1'b1},
    {5'b10110, 2'd0, 32'h0000_0003, 32'h0002_0000, 1'b0},
    {5'b11110, 2'd1, 32'h0000_0009, 32'h0000_0001, 1'b1},
    {5'b11100, 2'd2, 32'h0000_0006, 32'h0000_0010, 1'b1},
    {5'b10100, 2'd3, 32'h0000_0001, 32'h0000_E000, 1'b0},
    {5'b11000, 2'd0, 32'h0000_0002, 32'h0100_0000, 1'b1},
    {5'b01000, 2'd1, 32'h7FFF_FFFE, 32'h0001_0000, 1'b1},
    {5'b11000, 2'd2, 32'h7FFF_FFFE, 32'h0001_0000, 1'b0}
  };

  function automatic logic [31:0] mk(input logic [4:0] i5, input logic [1:0] rv,
                                     input logic [3:0] pm, input logic [3:0] pn,
                                     input logic [3:0] pd);
    return {8'h25, i5[4], i5[3], 1'b1, i5[2:0], rv, 2'b01, pm, 1'b0, pn, 1'b0, pd};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    insn = w; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pred_file[3*PL +: PL] = SRC;
    repeat (3) @(negedge clk);
    chk({wr_en, op_undef, op_foreign} == 3'b000 && in_ready, "R9 reset",
        {60'b0, wr_en, op_undef, op_foreign, in_ready}, 64'h1);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 11; i++) begin
      logic [4:0] i5; logic [1:0] rv; logic [31:0] ix, g; logic h;
      {i5, rv, ix, g, h} = VEC[i];
      for (int k = 0; k < 4; k++) idx_regs[k*32 +: 32] = ix + 32'd1;
      idx_regs[rv*32 +: 32] = ix;
      pred_file[9*PL +: PL] = g;
      issue(mk(i5, rv, 4'd9, 4'd3, 4'(i)));
      chk(wr_en && !op_undef && !op_foreign, "R8 write strobe",
          {61'b0, wr_en, op_undef, op_foreign}, 64'h4);
      chk(wr_addr == 4'(i), "R6 dest", {60'b0, wr_addr}, 64'(i));
      chk(wr_data == (h ? SRC : 32'h0), "R3 R4 R5 R6 R7 select",
          {32'b0, wr_data}, {32'b0, h ? SRC : 32'h0});
    end

    @(negedge clk);
    chk(!wr_en && !op_undef && !op_foreign, "R8 single-cycle pulse",
        {61'b0, wr_en, op_undef, op_foreign}, 64'h0);

    pred_file[9*PL +: PL] = 32'hFFFF_FFFF;
    issue(mk(5'b10000, 2'd0, 4'd9, 4'd3, 4'd5));
    chk(op_undef && !wr_en && !op_foreign, "R2 undefined size",
        {61'b0, wr_en, op_undef, op_foreign}, 64'h2);
    issue(mk(5'b00000, 2'd0, 4'd9, 4'd3, 4'd5));
    chk(op_undef && !wr_en, "R2 undefined size zero imm",
        {62'b0, wr_en, op_undef}, 64'h1);

    issue(mk(5'b00001, 2'd0, 4'd9, 4'd3, 4'd5) | 32'h0000_0200);
    chk(op_foreign && !wr_en && !op_undef, "R1 bit9 set",
        {61'b0, wr_en, op_undef, op_foreign}, 64'h1);
    issue(mk(5'b00001, 2'd0, 4'd9, 4'd3, 4'd5) ^ 32'h0100_0000);
    chk(op_foreign && !wr_en, "R1 opcode byte", {62'b0, wr_en, op_foreign}, 64'h1);
    issue(mk(5'b00001, 2'd0, 4'd9, 4'd3, 4'd5) & ~32'h0020_0000);
    chk(op_foreign && !wr_en, "R1 bit21 clear", {62'b0, wr_en, op_foreign}, 64'h1);
    issue(mk(5'b00000, 2'd0, 4'd9, 4'd3, 4'd5) | 32'h0000_0010);
    chk(op_foreign && !op_undef, "R1 precedes R2", {62'b0, op_undef, op_foreign}, 64'h1);

    @(negedge clk);
    insn = mk(5'b00001, 2'd0, 4'd9, 4'd3, 4'd5);
    repeat (2) @(negedge clk);
    chk(!wr_en && !op_undef && !op_foreign, "R8 no issue no output",
        {61'b0, wr_en, op_undef, op_foreign}, 64'h0);

    @(negedge clk);
    insn = mk(5'b00001, 2'd0, 4'd9, 4'd3, 4'd1); in_valid = 1;
    @(negedge clk);
    chk(wr_en && wr_addr == 4'd1, "R8 back-to-back first", {59'b0, wr_en, wr_addr}, 64'h11);
    insn = mk(5'b00001, 2'd0, 4'd9, 4'd3, 4'd2);
    @(negedge clk);
    in_valid = 0;
    chk(wr_en && wr_addr == 4'd2 && wr_data == SRC, "R8 back-to-back second",
        {27'b0, wr_en, wr_addr, wr_data}, {27'b0, 1'b1, 4'd2, SRC});

    issue(mk(5'b00001, 2'd0, 4'd9, 4'd3, 4'd5));
    rst_n = 0;
    @(negedge clk);
    chk(!wr_en && !op_undef && !op_foreign, "R9 reset clears",
        {61'b0, wr_en, op_undef, op_foreign}, 64'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule